// File: doc/BRIEF.md
# AXI4-Lite Byte Register Bank

This block keeps a parameterized number of byte-wide registers in flip-flops. Two sides can reach them. An AXI4-Lite slave port reads and writes whole data words, and each byte has a fixed home: byte `i` lives in word `i / STRB_W` on lane `i % STRB_W`. A per-byte logic side can load any byte directly, sees the current value of every byte, and receives one-cycle strobes that mark which bytes the bus is writing or reading.

The AXI channels follow valid/ready rules. A write is held in the block until both its address and its data have been accepted. After that, `s_awready` and `s_wready` stay low until the B response has been taken. While a logic-side load is active on a writable byte that the pending write touches, the write waits. That wait is the only back-pressure coming from the logic side. A read answers one cycle after its address handshake. `s_arready` stays low while an R beat waits for `s_rready`. A parameter mask marks bytes as read-only for the bus. Two parameter switches restrict access to privileged and/or secure transactions. Bytes reset asynchronously to per-byte parameter values.

Top module: `lite_byte_bank`

## Requirements
- R1: While `rst_n` is low, byte `i` of `reg_q` holds byte `i` of `RST_VAL`, and `s_bvalid` and `s_rvalid` are low.
- R2: Only address bits `[clog2(NUM_BYTES)-1 : clog2(STRB_W)]` select the word. Higher bits and the lane bits below that field have no effect. Byte `i` appears on data lane `i % STRB_W` of word `i / STRB_W`.
- R3: A word whose first byte index is NUM_BYTES or more is out of range. A write to it changes no byte and returns SLVERR (2'b10). A read of it returns SLVERR with all-zero data.
- R4: A byte whose `RO_MASK` bit is 1 is never changed by a bus write. It can still be read over the bus, and a logic-side load still changes it.
- R5: A write updates every strobed, implemented, writable byte from its lane. It returns OKAY (2'b00) if at least one byte was updated. It returns SLVERR if none was, for example when every strobed lane is read-only or unimplemented.
- R6: With `PRIV_ONLY`=1 an access needs prot bit 0 set. With `SECURE_ONLY`=1 it needs prot bit 1 set. A rejected access returns SLVERR, changes no byte, reads as zero, and raises no activity strobe.
- R7: While `load_en[i]` is high, byte `i` takes `load_data` byte `i` at the next rising edge.
- R8: A pending write whose strobes cover a writable byte with `load_en` high does not commit. It commits in the first cycle in which no such load is active.
- R9: `wr_active[i]` is high for exactly the commit cycle of an accepted write that strobes implemented byte `i`, whether or not that byte is read-only.
- R10: `rd_active[i]` is high in the AR handshake cycle of an accepted read whose word contains byte `i`.
- R11: A write is accepted only after both the AW and W handshakes. At most one write and one read are outstanding. `s_bvalid`/`s_bresp` and `s_rvalid`/`s_rdata`/`s_rresp` hold until ready. R follows the AR handshake by one cycle, and lanes beyond the last byte read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_awprot | input | 3 | Write protection bits |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write lane strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection bits |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| load_en | input | NUM_BYTES | Per-byte load enable |
| load_data | input | 8*NUM_BYTES | Per-byte load value |
| reg_q | output | 8*NUM_BYTES | Current value of every byte |
| wr_active | output | NUM_BYTES | Bus write commit strobe per byte |
| rd_active | output | NUM_BYTES | Bus read strobe per byte |

## Verification
The hardest case to reach is a write stall. It needs a logic-side load on a writable byte that is still active after the write has been captured. It also needs a load on a read-only byte in the same word, which must not stall the write. The stimulus raises the load enables in the same cycle as the AW and W handshakes and holds them for several cycles. During those cycles it checks that no commit strobe and no response appears. It then releases the load and checks that the write lands one cycle later. Around that case, a sweep covers every strobe pattern, every word (including the out-of-range one) and every protection value. Each response and byte value is compared against a byte model kept in the bench.

// File: rtl/lbb_pkg.sv
package lbb_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/lbb_byte_cell.sv
module lbb_byte_cell #(
  parameter logic [7:0] RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_d,
  input  logic       wr,
  input  logic [7:0] wr_d,
  output logic [7:0] q
);
  // A load and a write never collide on a writable byte (the write stalls).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (load) q <= load_d;
    else if (wr)   q <= wr_d;
  end
endmodule

// File: rtl/lbb_write_ctrl.sv
module lbb_write_ctrl
  import lbb_pkg::*;
#(
  parameter int unsigned          NUM_BYTES   = 9,
  parameter int unsigned          DATA_W      = 32,
  parameter int unsigned          CHUNK_W     = 2,
  parameter bit                   PRIV_ONLY   = 1'b1,
  parameter bit                   SECURE_ONLY = 1'b1,
  parameter logic [NUM_BYTES-1:0] RO_MASK     = '0,
  localparam int unsigned         STRB_W      = DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   awvalid,
  output logic                   awready,
  input  logic [CHUNK_W-1:0]     aw_chunk,
  input  logic [1:0]             awprot,
  input  logic                   wvalid,
  output logic                   wready,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [STRB_W-1:0]      wstrb,
  output logic                   bvalid,
  input  logic                   bready,
  output logic [1:0]             bresp,
  input  logic [NUM_BYTES-1:0]   load_en,
  output logic [NUM_BYTES-1:0]   wr_en,
  output logic [8*NUM_BYTES-1:0] wr_data,
  output logic [NUM_BYTES-1:0]   wr_active
);
  logic                 aw_full, w_full;
  logic [CHUNK_W-1:0]   chunk_q;
  logic [1:0]           prot_q;
  logic [DATA_W-1:0]    data_q;
  logic [STRB_W-1:0]    strb_q;
  logic                 pending, prot_ok, stall, commit;
  logic [NUM_BYTES-1:0] hit, blocked;

  assign awready = !aw_full && !bvalid;
  assign wready  = !w_full && !bvalid;
  assign pending = aw_full && w_full;
  assign prot_ok = (!PRIV_ONLY || prot_q[0]) && (!SECURE_ONLY || prot_q[1]);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    assign hit[i] = pending && prot_ok && (chunk_q == CHUNK_W'(i / STRB_W))
                    && strb_q[i % STRB_W];
    assign blocked[i] = hit[i] && !RO_MASK[i] && load_en[i];
    assign wr_data[8*i +: 8] = data_q[8*(i % STRB_W) +: 8];
  end

  assign stall     = |blocked;
  assign commit    = pending && !stall;
  assign wr_active = commit ? hit : '0;
  assign wr_en     = wr_active & ~RO_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      chunk_q <= '0;
      prot_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      bvalid  <= 1'b0;
      bresp   <= RESP_OKAY;
    end else begin
      if (awvalid && awready) begin
        aw_full <= 1'b1;
        chunk_q <= aw_chunk;
        prot_q  <= awprot;
      end
      if (wvalid && wready) begin
        w_full <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (commit) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
        bvalid  <= 1'b1;
        bresp   <= (|wr_en) ? RESP_OKAY : RESP_SLVERR;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lbb_read_ctrl.sv
module lbb_read_ctrl
  import lbb_pkg::*;
#(
  parameter int unsigned  NUM_BYTES   = 9,
  parameter int unsigned  DATA_W      = 32,
  parameter int unsigned  CHUNK_W     = 2,
  parameter bit           PRIV_ONLY   = 1'b1,
  parameter bit           SECURE_ONLY = 1'b1,
  localparam int unsigned STRB_W      = DATA_W / 8,
  localparam int unsigned NUM_CHUNKS  = (NUM_BYTES + STRB_W - 1) / STRB_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arvalid,
  output logic                   arready,
  input  logic [CHUNK_W-1:0]     ar_chunk,
  input  logic [1:0]             arprot,
  output logic                   rvalid,
  input  logic                   rready,
  output logic [DATA_W-1:0]      rdata,
  output logic [1:0]             rresp,
  input  logic [8*NUM_BYTES-1:0] reg_q,
  output logic [NUM_BYTES-1:0]   rd_active
);
  logic                 hs, prot_ok, in_range;
  logic [NUM_BYTES-1:0] sel;
  logic [DATA_W-1:0]    data_next;

  assign arready  = !rvalid;
  assign hs       = arvalid && arready;
  assign prot_ok  = (!PRIV_ONLY || arprot[0]) && (!SECURE_ONLY || arprot[1]);
  assign in_range = {1'b0, ar_chunk} < (CHUNK_W + 1)'(NUM_CHUNKS);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sel
    assign sel[i] = hs && prot_ok && (ar_chunk == CHUNK_W'(i / STRB_W));
  end
  assign rd_active = sel;

  always_comb begin
    data_next = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (sel[i]) data_next[8*(i % STRB_W) +: 8] = reg_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
    end else if (hs) begin
      rvalid <= 1'b1;
      rdata  <= data_next;
      rresp  <= (prot_ok && in_range) ? RESP_OKAY : RESP_SLVERR;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/lite_byte_bank.sv
module lite_byte_bank #(
  parameter int unsigned            NUM_BYTES   = 9,
  parameter int unsigned            ADDR_W      = 8,
  parameter int unsigned            DATA_W      = 32,
  parameter bit                     PRIV_ONLY   = 1'b1,
  parameter bit                     SECURE_ONLY = 1'b1,
  parameter logic [NUM_BYTES-1:0]   RO_MASK     = 9'h045,
  parameter logic [8*NUM_BYTES-1:0] RST_VAL     = 72'hA8A7A6A5A4A3A2A1A0,
  localparam int unsigned           STRB_W      = DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_awvalid,
  output logic                   s_awready,
  input  logic [ADDR_W-1:0]      s_awaddr,
  input  logic [2:0]             s_awprot,
  input  logic                   s_wvalid,
  output logic                   s_wready,
  input  logic [DATA_W-1:0]      s_wdata,
  input  logic [STRB_W-1:0]      s_wstrb,
  output logic                   s_bvalid,
  input  logic                   s_bready,
  output logic [1:0]             s_bresp,
  input  logic                   s_arvalid,
  output logic                   s_arready,
  input  logic [ADDR_W-1:0]      s_araddr,
  input  logic [2:0]             s_arprot,
  output logic                   s_rvalid,
  input  logic                   s_rready,
  output logic [DATA_W-1:0]      s_rdata,
  output logic [1:0]             s_rresp,
  input  logic [NUM_BYTES-1:0]   load_en,
  input  logic [8*NUM_BYTES-1:0] load_data,
  output logic [8*NUM_BYTES-1:0] reg_q,
  output logic [NUM_BYTES-1:0]   wr_active,
  output logic [NUM_BYTES-1:0]   rd_active
);
  localparam int unsigned LANE_W  = $clog2(STRB_W);
  localparam int unsigned OFF_W   = $clog2(NUM_BYTES);
  localparam int unsigned CHUNK_W = (OFF_W > LANE_W) ? OFF_W - LANE_W : 1;

  logic [CHUNK_W-1:0]     aw_chunk, ar_chunk;
  logic [NUM_BYTES-1:0]   wr_en;
  logic [8*NUM_BYTES-1:0] wr_data;
  logic                   unused_bits;

  // Word select comes from the offset field only (R2).
  if (OFF_W > LANE_W) begin : g_chunk
    assign aw_chunk = s_awaddr[OFF_W-1:LANE_W];
    assign ar_chunk = s_araddr[OFF_W-1:LANE_W];
  end else begin : g_single
    assign aw_chunk = '0;
    assign ar_chunk = '0;
  end
  assign unused_bits = ^{s_awaddr, s_araddr, s_awprot[2], s_arprot[2]};

  lbb_write_ctrl #(
    .NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .CHUNK_W(CHUNK_W),
    .PRIV_ONLY(PRIV_ONLY), .SECURE_ONLY(SECURE_ONLY), .RO_MASK(RO_MASK)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .aw_chunk(aw_chunk),
    .awprot(s_awprot[1:0]),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .load_en(load_en), .wr_en(wr_en), .wr_data(wr_data), .wr_active(wr_active)
  );

  lbb_read_ctrl #(
    .NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .CHUNK_W(CHUNK_W),
    .PRIV_ONLY(PRIV_ONLY), .SECURE_ONLY(SECURE_ONLY)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(s_arvalid), .arready(s_arready), .ar_chunk(ar_chunk),
    .arprot(s_arprot[1:0]),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .reg_q(reg_q), .rd_active(rd_active)
  );

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_cell
    lbb_byte_cell #(.RST(RST_VAL[8*i +: 8])) u_cell (
      .clk(clk), .rst_n(rst_n),
      .load(load_en[i]), .load_d(load_data[8*i +: 8]),
      .wr(wr_en[i]), .wr_d(wr_data[8*i +: 8]),
      .q(reg_q[8*i +: 8])
    );
  end
endmodule

// File: rtl/lbb_checker.sv
module lbb_checker #(
  parameter int unsigned          NUM_BYTES = 9,
  parameter int unsigned          DATA_W    = 32,
  parameter logic [NUM_BYTES-1:0] RO_MASK   = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_bvalid,
  input logic                   s_bready,
  input logic [1:0]             s_bresp,
  input logic                   s_rvalid,
  input logic                   s_rready,
  input logic [DATA_W-1:0]      s_rdata,
  input logic [1:0]             s_rresp,
  input logic [NUM_BYTES-1:0]   load_en,
  input logic [8*NUM_BYTES-1:0] reg_q,
  input logic [NUM_BYTES-1:0]   wr_active,
  input logic [NUM_BYTES-1:0]   rd_active
);
  a_r11_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));

  a_r11_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));

  a_r9_commit_gives_b: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_active) |=> s_bvalid);

  a_r10_read_gives_r: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_active) |=> s_rvalid);

  a_r8_no_commit_under_load: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_active & load_en & ~RO_MASK) == '0));

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_ro
    if (RO_MASK[i]) begin : g_chk
      a_r4_ro_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en[i] |=> reg_q[8*i +: 8] == $past(reg_q[8*i +: 8]));
    end
  end
endmodule

bind lite_byte_bank lbb_checker #(
  .NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .RO_MASK(RO_MASK)
) u_lbb_checker (
  .clk(clk), .rst_n(rst_n),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
  .load_en(load_en), .reg_q(reg_q), .wr_active(wr_active), .rd_active(rd_active)
);

// File: tb/lite_byte_bank_bench.sv
module lite_byte_bank_bench;
  localparam int          N   = 9;
  localparam logic [8:0]  RO  = 9'h045;
  localparam logic [71:0] RSTV = 72'hA8A7A6A5A4A3A2A1A0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [7:0]  s_awaddr = 0, s_araddr = 0;
  logic [2:0]  s_awprot = 0, s_arprot = 0;
  logic [31:0] s_wdata = 0, s_rdata;
  logic [3:0]  s_wstrb = 0;
  logic [1:0]  s_bresp, s_rresp;
  logic [8:0]  load_en = 0, wr_active, rd_active;
  logic [71:0] load_data = 0, reg_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [N];

  always #5 clk = ~clk;

  lite_byte_bank #(
    .NUM_BYTES(N), .ADDR_W(8), .DATA_W(32), .PRIV_ONLY(1'b1), .SECURE_ONLY(1'b1),
    .RO_MASK(RO), .RST_VAL(RSTV)
  ) u_lite_byte_bank (.*);

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [71:0] model_vec();
    logic [71:0] v;
    for (int i = 0; i < N; i++) v[8*i +: 8] = m[i];
    return v;
  endfunction

  task automatic axi_write(input logic [7:0] addr, input logic [2:0] prot,
                           input logic [31:0] data, input logic [3:0] strb, input string tag);
    logic [8:0] act;
    logic       any;
    int         c;
    c = int'(addr[3:2]);
    act = '0;
    any = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = c * 4 + k;
      if (prot[1:0] == 2'b11 && idx < N && strb[k]) begin
        act[idx] = 1'b1;
        if (!RO[idx]) any = 1'b1;
      end
    end
    @(negedge clk);
    s_awvalid = 1; s_awaddr = addr; s_awprot = prot;
    s_wvalid = 1; s_wdata = data; s_wstrb = strb;
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    chk({tag, " wr_active"}, 128'(wr_active), 128'(act));
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = c * 4 + k;
      if (idx < N && act[idx] && !RO[idx]) m[idx] = data[8*k +: 8];
    end
    chk({tag, " bvalid"}, 128'(s_bvalid), 128'(1));
    chk({tag, " bresp"}, 128'(s_bresp), 128'(any ? 2'b00 : 2'b10));
    chk({tag, " reg_q"}, 128'(reg_q), 128'(model_vec()));
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
    chk({tag, " bvalid drop"}, 128'(s_bvalid), 128'(0));
  endtask

  task automatic axi_read(input logic [7:0] addr, input logic [2:0] prot, input string tag);
    logic [8:0]  act;
    logic [31:0] d;
    logic        ok;
    int          c;
    c = int'(addr[3:2]);
    ok = (prot[1:0] == 2'b11) && (c < 3);
    act = '0;
    d = '0;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = c * 4 + k;
      if (prot[1:0] == 2'b11 && idx < N) begin
        act[idx] = 1'b1;
        d[8*k +: 8] = m[idx];
      end
    end
    @(negedge clk);
    s_arvalid = 1; s_araddr = addr; s_arprot = prot;
    #1;
    chk({tag, " rd_active"}, 128'(rd_active), 128'(act));
    @(negedge clk);
    s_arvalid = 0;
    chk({tag, " rvalid"}, 128'(s_rvalid), 128'(1));
    chk({tag, " rdata"}, 128'(s_rdata), 128'(d));
    chk({tag, " rresp"}, 128'(s_rresp), 128'(ok ? 2'b00 : 2'b10));
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 got hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m[i] = 8'hA0 + 8'(i);
    repeat (2) @(negedge clk);
    chk("R1 reg_q in reset", 128'(reg_q), 128'(RSTV));
    chk("R1 bvalid in reset", 128'(s_bvalid), 128'(0));
    chk("R1 rvalid in reset", 128'(s_rvalid), 128'(0));
    rst_n = 1;

    // R1 R2 R3 R10 R11: read every word after reset
    for (int c = 0; c < 4; c++) axi_read({4'h5, 2'(c), 2'b01}, 3'b011, "R1 R10 R11 read");

    // R2 R3 R4 R5 R6 R9: every protection value, word and strobe pattern
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        for (int s = 1; s < 16; s++) begin
          logic [31:0] data;
          string tag;
          data = 32'h9E3779B9 * 32'(p * 64 + c * 16 + s + 1);
          if (p != 3) tag = "R6 write";
          else if (c == 3) tag = "R3 write";
          else tag = "R2 R4 R5 R9 write";
          axi_write({4'(p * 5 + s), 2'(c), 2'(s)}, 3'(p) | 3'b100, data, 4'(s), tag);
        end

    // R2 R3 R6 R10 R11: read every word under every protection value
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        axi_read({4'(15 - p), 2'(c), 2'(p)}, 3'(p), "R2 R3 R6 R10 read");

    // R7 R4: logic-side load of every byte, read-only ones included
    @(negedge clk);
    load_en = 9'h1FF;
    load_data = 72'h1122334455667788_99;
    @(negedge clk);
    load_en = 0;
    for (int i = 0; i < N; i++) m[i] = load_data[8*i +: 8];
    chk("R7 R4 load", 128'(reg_q), 128'(model_vec()));

    // R8: write stalled by a load on the same writable byte
    @(negedge clk);
    load_en = 9'h002;
    load_data = 72'h5A << 8;
    s_awvalid = 1; s_awaddr = 8'h00; s_awprot = 3'b011;
    s_wvalid = 1; s_wdata = 32'h0000_7700; s_wstrb = 4'b0010;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    m[1] = 8'h5A;
    chk("R8 no commit strobe", 128'(wr_active), 128'(0));
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R8 no response", 128'(s_bvalid), 128'(0));
      chk("R11 aw blocked", 128'(s_awready), 128'(0));
      chk("R8 load wins", 128'(reg_q), 128'(model_vec()));
    end
    load_en = 0;
    #1;
    chk("R9 R8 commit strobe", 128'(wr_active), 128'(9'h002));
    @(negedge clk);
    m[1] = 8'h77;
    chk("R8 bvalid", 128'(s_bvalid), 128'(1));
    chk("R8 bresp", 128'(s_bresp), 128'(2'b00));
    chk("R8 reg_q", 128'(reg_q), 128'(model_vec()));
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;

    // R8 R9 R4: a load on a read-only byte does not stall
    load_en = 9'h001;
    load_data = 72'h3C;
    s_awvalid = 1; s_awaddr = 8'h00; s_awprot = 3'b011;
    s_wvalid = 1; s_wdata = 32'h0000_6655; s_wstrb = 4'b0011;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    chk("R9 R4 strobe on ro byte", 128'(wr_active), 128'(9'h003));
    @(negedge clk);
    load_en = 0;
    m[0] = 8'h3C;
    m[1] = 8'h66;
    chk("R8 ro load no stall bvalid", 128'(s_bvalid), 128'(1));
    chk("R8 ro load bresp", 128'(s_bresp), 128'(2'b00));
    chk("R4 R8 reg_q", 128'(reg_q), 128'(model_vec()));

    // R11: response held without bready
    for (int n = 0; n < 2; n++) begin
      @(negedge clk);
      chk("R11 bvalid held", 128'(s_bvalid), 128'(1));
      chk("R11 bresp held", 128'(s_bresp), 128'(2'b00));
      chk("R11 wready low", 128'(s_wready), 128'(0));
    end
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
    chk("R11 bvalid released", 128'(s_bvalid), 128'(0));

    // R11: address first, data later; no commit before both
    s_awvalid = 1; s_awaddr = 8'h04; s_awprot = 3'b011;
    @(negedge clk);
    s_awvalid = 0;
    @(negedge clk);
    chk("R11 no commit without W", 128'(s_bvalid), 128'(0));
    chk("R11 no strobe without W", 128'(wr_active), 128'(0));
    s_wvalid = 1; s_wdata = 32'hC3000000; s_wstrb = 4'b1000;
    @(negedge clk);
    s_wvalid = 0;
    chk("R11 R9 strobe after W", 128'(wr_active), 128'(9'h080));
    @(negedge clk);
    m[7] = 8'hC3;
    chk("R11 bvalid", 128'(s_bvalid), 128'(1));
    chk("R11 reg_q", 128'(reg_q), 128'(model_vec()));
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;

    axi_read(8'h08, 3'b011, "R11 zero lanes");
    axi_read(8'h04, 3'b111, "R2 R5 readback");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule